// File: doc/BRIEF.md
# Dense Four-Trit Seven-Bit Codec

This block packs four balanced-ternary digits into a 7-bit binary word and unpacks such words again. It is used wherever small ternary weights or sign masks (keep, negate, zero) are stored or moved in binary form. Packing costs 7 bits instead of the 8 that four 2-bit fields would take. Each trit travels on the ports as a 2-bit value: 0 means zero, 1 means plus one, 2 means minus one, and 3 is illegal.

The word is not a base-3 number. It is laid out by cases, according to which digits are minus one. The top bit and two 3-bit groups below it select the case, and the remaining bits carry the 0/1 digits directly. Each decoded trit therefore depends on only a few code bits. The encoder path and the decoder path are independent. Each has a valid input and a registered result one cycle later. The decoder flags every 7-bit word that the encoder never emits.

Top module: `ttc_codec`

## Requirements
- R1: While rst_ni is low, and after reset until the first valid input, enc_valid_o and dec_valid_o are 0, and enc_code_o, enc_lane_bad_o, dec_trits_o and dec_invalid_o are 0.
- R2: The encoder result (enc_code_o, enc_lane_bad_o) appears with enc_valid_o high exactly one clock after enc_valid_i is high. In a cycle after enc_valid_i was low, enc_valid_o is 0 and the result holds its last value.
- R3: Trit lane k occupies enc_trits_i[2k+1:2k], with lane 0 = a, 1 = b, 2 = c, 3 = d. When every lane is 0 or 1, the code is {0,0,a,b,0,c,d}, where code bit 6 is the leftmost bit.
- R4: Writing the code MSB first, and with x positions driven to 0, the layouts with minus-one digits are: d only 00ab10c; c only 00ab11d; b only 010a0cd; a only 011b0cd; b,d 010a10c; a,d 011b10c; b,c 010a11d; a,c 011b11d; c,d 10ab10x; a,b 110x0cd; b,c,d 100a110; a,c,d 101b110; a,b,d 111000c; a,b,c 111001d; all four 1110110.
- R5: Decoding the code of any of the 81 legal trit combinations returns the same four trits, with dec_invalid_o low.
- R6: The 81 legal combinations give 81 distinct codes, and none of them has the form 10xx0xx.
- R7: enc_lane_bad_o[k] is 1 exactly when lane k holds 3. When any bit of enc_lane_bad_o is set, enc_code_o is 0.
- R8: For each of the 47 words that the encoder never produces, dec_invalid_o is 1 and dec_trits_o is 0. These include 10xx0xx, 1111xxx, and words with a nonzero x position.
- R9: The decoder result (dec_trits_o, dec_invalid_o) appears with dec_valid_o high exactly one clock after dec_valid_i is high. After a cycle with dec_valid_i low, dec_valid_o is 0 and the result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_trits_i | input | 8 | Four 2-bit trits, lane a in the low bits |
| enc_valid_o | output | 1 | Encoder result valid |
| enc_code_o | output | 7 | Packed code word |
| enc_lane_bad_o | output | 4 | Per-lane flag for the illegal value 3 |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_code_i | input | 7 | Code word to unpack |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_trits_o | output | 8 | Four decoded 2-bit trits |
| dec_invalid_o | output | 1 | Code word is not a canonical encoding |

## Verification
Both the encoded word and the decoded trits are due at the first rising edge after their valid input is applied. The bench changes inputs on the falling edge and reads results on the next falling edge, so it always samples half a period after the register that holds the result has loaded. Each code produced in the 81-combination sweep is fed straight back into the decoder and read one falling edge later. Idle cycles are inserted to confirm that the valid output drops while the result holds its last value.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int TRIT_W    = 2;
  localparam int NUM_TRITS = 4;
  localparam int CODE_W    = 7;
  localparam int LANES_W   = TRIT_W * NUM_TRITS;
  localparam logic [TRIT_W-1:0] TRIT_ZERO = 2'd0;
  localparam logic [TRIT_W-1:0] TRIT_NEG  = 2'd2;
  localparam logic [TRIT_W-1:0] TRIT_BAD  = 2'd3;
endpackage

// File: rtl/ttc_out_reg.sv
module ttc_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/ttc_enc_core.sv
module ttc_enc_core
  import ttc_pkg::*;
(
  input  logic [LANES_W-1:0]   trits_i,
  output logic [CODE_W-1:0]    code_o,
  output logic [NUM_TRITS-1:0] lane_bad_o
);
  logic [NUM_TRITS-1:0] neg;  // {d,c,b,a}
  logic [NUM_TRITS-1:0] one;
  logic [CODE_W-1:0]    raw;

  for (genvar k = 0; k < NUM_TRITS; k++) begin : g_lane
    logic [TRIT_W-1:0] t;
    assign t             = trits_i[k*TRIT_W +: TRIT_W];
    assign neg[k]        = (t == TRIT_NEG);
    assign lane_bad_o[k] = (t == TRIT_BAD);
    assign one[k]        = (t == 2'd1);
  end

  logic a, b, c, d;
  assign {d, c, b, a} = one;

  // case key written a,b,c,d from left
  always_comb begin
    unique case ({neg[0], neg[1], neg[2], neg[3]})
      4'b0000: raw = {2'b00, a, b, 1'b0, c, d};
      4'b0001: raw = {2'b00, a, b, 2'b10, c};
      4'b0010: raw = {2'b00, a, b, 2'b11, d};
      4'b0100: raw = {3'b010, a, 1'b0, c, d};
      4'b1000: raw = {3'b011, b, 1'b0, c, d};
      4'b0101: raw = {3'b010, a, 2'b10, c};
      4'b1001: raw = {3'b011, b, 2'b10, c};
      4'b0110: raw = {3'b010, a, 2'b11, d};
      4'b1010: raw = {3'b011, b, 2'b11, d};
      4'b0011: raw = {2'b10, a, b, 3'b100};
      4'b1100: raw = {4'b1100, 1'b0, c, d};
      4'b0111: raw = {3'b100, a, 3'b110};
      4'b1011: raw = {3'b101, b, 3'b110};
      4'b1101: raw = {6'b111000, c};
      4'b1110: raw = {6'b111001, d};
      default: raw = 7'b1110110;
    endcase
  end

  assign code_o = (|lane_bad_o) ? '0 : raw;
endmodule

// File: rtl/ttc_dec_core.sv
module ttc_dec_core
  import ttc_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  output logic [LANES_W-1:0] trits_o,
  output logic               invalid_o
);
  logic [TRIT_W-1:0] ta, tb, tc, td;
  logic              hit;
  logic [LANES_W-1:0] cand;
  logic [CODE_W-1:0]  recode;
  logic [NUM_TRITS-1:0] re_bad;

  function automatic logic [TRIT_W-1:0] bin(input logic v);
    return {1'b0, v};
  endfunction

  always_comb begin
    hit = 1'b1;
    ta = TRIT_ZERO; tb = TRIT_ZERO; tc = TRIT_ZERO; td = TRIT_ZERO;
    casez (code_i)
      7'b00??0??: begin ta = bin(code_i[4]); tb = bin(code_i[3]); tc = bin(code_i[1]); td = bin(code_i[0]); end
      7'b00??10?: begin ta = bin(code_i[4]); tb = bin(code_i[3]); tc = bin(code_i[0]); td = TRIT_NEG; end
      7'b00??11?: begin ta = bin(code_i[4]); tb = bin(code_i[3]); tc = TRIT_NEG; td = bin(code_i[0]); end
      7'b010?0??: begin ta = bin(code_i[3]); tb = TRIT_NEG; tc = bin(code_i[1]); td = bin(code_i[0]); end
      7'b011?0??: begin ta = TRIT_NEG; tb = bin(code_i[3]); tc = bin(code_i[1]); td = bin(code_i[0]); end
      7'b010?10?: begin ta = bin(code_i[3]); tb = TRIT_NEG; tc = bin(code_i[0]); td = TRIT_NEG; end
      7'b011?10?: begin ta = TRIT_NEG; tb = bin(code_i[3]); tc = bin(code_i[0]); td = TRIT_NEG; end
      7'b010?11?: begin ta = bin(code_i[3]); tb = TRIT_NEG; tc = TRIT_NEG; td = bin(code_i[0]); end
      7'b011?11?: begin ta = TRIT_NEG; tb = bin(code_i[3]); tc = TRIT_NEG; td = bin(code_i[0]); end
      7'b10??10?: begin ta = bin(code_i[4]); tb = bin(code_i[3]); tc = TRIT_NEG; td = TRIT_NEG; end
      7'b100?11?: begin ta = bin(code_i[3]); tb = TRIT_NEG; tc = TRIT_NEG; td = TRIT_NEG; end
      7'b101?11?: begin ta = TRIT_NEG; tb = bin(code_i[3]); tc = TRIT_NEG; td = TRIT_NEG; end
      7'b110?0??: begin ta = TRIT_NEG; tb = TRIT_NEG; tc = bin(code_i[1]); td = bin(code_i[0]); end
      7'b111000?: begin ta = TRIT_NEG; tb = TRIT_NEG; tc = bin(code_i[0]); td = TRIT_NEG; end
      7'b111001?: begin ta = TRIT_NEG; tb = TRIT_NEG; tc = TRIT_NEG; td = bin(code_i[0]); end
      7'b111011?: begin ta = TRIT_NEG; tb = TRIT_NEG; tc = TRIT_NEG; td = TRIT_NEG; end
      default:    hit = 1'b0;
    endcase
  end

  assign cand = {td, tc, tb, ta};

  // canonical check: only words the encoder itself emits are accepted
  ttc_enc_core u_recode (
    .trits_i   (cand),
    .code_o    (recode),
    .lane_bad_o(re_bad)
  );

  assign invalid_o = !hit || (recode != code_i) || (|re_bad);
  assign trits_o   = invalid_o ? '0 : cand;
endmodule

// File: rtl/ttc_codec.sv
module ttc_codec
  import ttc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enc_valid_i,
  input  logic [LANES_W-1:0]   enc_trits_i,
  output logic                 enc_valid_o,
  output logic [CODE_W-1:0]    enc_code_o,
  output logic [NUM_TRITS-1:0] enc_lane_bad_o,
  input  logic                 dec_valid_i,
  input  logic [CODE_W-1:0]    dec_code_i,
  output logic                 dec_valid_o,
  output logic [LANES_W-1:0]   dec_trits_o,
  output logic                 dec_invalid_o
);
  localparam int ENC_RES_W = CODE_W + NUM_TRITS;
  localparam int DEC_RES_W = LANES_W + 1;

  logic [CODE_W-1:0]    enc_code;
  logic [NUM_TRITS-1:0] enc_bad;
  logic [LANES_W-1:0]   dec_trits;
  logic                 dec_bad;

  ttc_enc_core u_enc (
    .trits_i   (enc_trits_i),
    .code_o    (enc_code),
    .lane_bad_o(enc_bad)
  );

  ttc_dec_core u_dec (
    .code_i   (dec_code_i),
    .trits_o  (dec_trits),
    .invalid_o(dec_bad)
  );

  ttc_out_reg #(.W(ENC_RES_W)) u_enc_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(enc_valid_i),
    .data_i ({enc_bad, enc_code}),
    .valid_o(enc_valid_o),
    .data_o ({enc_lane_bad_o, enc_code_o})
  );

  ttc_out_reg #(.W(DEC_RES_W)) u_dec_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(dec_valid_i),
    .data_i ({dec_bad, dec_trits}),
    .valid_o(dec_valid_o),
    .data_o ({dec_invalid_o, dec_trits_o})
  );
endmodule

// File: rtl/ttc_codec_chk.sv
module ttc_codec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enc_valid_i,
  input logic [7:0] enc_trits_i,
  input logic       enc_valid_o,
  input logic [6:0] enc_code_o,
  input logic [3:0] enc_lane_bad_o,
  input logic       dec_valid_i,
  input logic [6:0] dec_code_i,
  input logic       dec_valid_o,
  input logic [7:0] dec_trits_o,
  input logic       dec_invalid_o
);
  AST_ENC_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o); // R2
  AST_ENC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o))); // R2
  AST_DEC_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o); // R9
  AST_DEC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> (!dec_valid_o && $stable(dec_trits_o))); // R9
  AST_LANE0_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_valid_i && enc_trits_i[1:0] == 2'b11) |=> enc_lane_bad_o[0]); // R7
  AST_BAD_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_valid_o && |enc_lane_bad_o) |-> enc_code_o == 7'd0); // R7
  AST_NOT_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_valid_o && !(|enc_lane_bad_o)) |-> !(enc_code_o[6:5] == 2'b10 && !enc_code_o[2])); // R6
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_invalid_o) |-> dec_trits_o == 8'd0); // R8
  AST_DEC_NO_THREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_trits_o[1:0] != 2'b11 && dec_trits_o[3:2] != 2'b11 &&
                     dec_trits_o[5:4] != 2'b11 && dec_trits_o[7:6] != 2'b11)); // R5
endmodule

bind ttc_codec ttc_codec_chk chk_i (.*);

// File: tb/ttc_codec_tb_top.sv
module ttc_codec_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enc_valid_i = 1'b0;
  logic [7:0] enc_trits_i = '0;
  logic       enc_valid_o;
  logic [6:0] enc_code_o;
  logic [3:0] enc_lane_bad_o;
  logic       dec_valid_i = 1'b0;
  logic [6:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [7:0] dec_trits_o;
  logic       dec_invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit seen [128];

  always #10 clk_i = ~clk_i;  // 50 MHz

  ttc_codec dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pack(input int a, input int b, input int c, input int d);
    return {d[1:0], c[1:0], b[1:0], a[1:0]};
  endfunction

  // drive on falling edge, result sampled on next falling edge
  task automatic enc(input logic [7:0] t);
    enc_trits_i = t; enc_valid_i = 1'b1;
    @(negedge clk_i);
    enc_valid_i = 1'b0;
  endtask

  task automatic dec(input logic [6:0] c);
    dec_code_i = c; dec_valid_i = 1'b1;
    @(negedge clk_i);
    dec_valid_i = 1'b0;
  endtask

  initial begin
    int n_valid;
    logic [6:0] held;
    @(negedge clk_i);
    check(enc_valid_o == 0 && dec_valid_o == 0 && enc_code_o == 0 && dec_trits_o == 0
          && enc_lane_bad_o == 0 && dec_invalid_o == 0, "R1", {enc_valid_o, dec_valid_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(enc_valid_o == 0 && dec_valid_o == 0 && enc_code_o == 0, "R1", enc_code_o, 0);

    // R4 spot layouts
    enc(pack(1,0,1,2)); check(enc_code_o == 7'b0010101, "R4 d", enc_code_o, 7'b0010101);
    enc(pack(2,2,1,1)); check(enc_code_o == 7'b1100011, "R4 ab", enc_code_o, 7'b1100011);
    enc(pack(2,2,2,2)); check(enc_code_o == 7'b1110110, "R4 all", enc_code_o, 7'b1110110);
    enc(pack(1,2,2,2)); check(enc_code_o == 7'b1001110, "R4 bcd", enc_code_o, 7'b1001110);
    enc(pack(2,1,2,0)); check(enc_code_o == 7'b0111110, "R4 ac", enc_code_o, 7'b0111110);
    enc(pack(1,1,2,2)); check(enc_code_o == 7'b1011100, "R4 cd", enc_code_o, 7'b1011100);
    enc(pack(2,2,2,1)); check(enc_code_o == 7'b1110011, "R4 abc", enc_code_o, 7'b1110011);
    enc(pack(0,2,1,0)); check(enc_code_o == 7'b0100010, "R4 b", enc_code_o, 7'b0100010);

    // R2 hold: idle cycle keeps last code, valid drops
    held = enc_code_o;
    enc_trits_i = pack(0,0,0,0);
    @(negedge clk_i);
    check(!enc_valid_o && enc_code_o == held, "R2", enc_code_o, held);

    // R7 illegal lanes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] t;
      t = pack(1,0,2,1);
      t[2*k +: 2] = 2'b11;
      enc(t);
      check(enc_valid_o && enc_lane_bad_o == (4'b1 << k) && enc_code_o == 0, "R7",
            {enc_lane_bad_o, enc_code_o}, (1 << k) << 7);
    end
    enc(8'hFF);
    check(enc_lane_bad_o == 4'hF && enc_code_o == 0, "R7", enc_lane_bad_o, 4'hF);

    // R3 R5 R6 full 81 sweep with round trip
    for (int i = 0; i < 128; i++) seen[i] = 1'b0;
    for (int i = 0; i < 81; i++) begin
      int a, b, c, d;
      logic [6:0] code;
      logic [7:0] t;
      a = i % 3; b = (i / 3) % 3; c = (i / 9) % 3; d = (i / 27) % 3;
      t = pack(a, b, c, d);
      enc(t);
      code = enc_code_o;
      check(enc_valid_o && enc_lane_bad_o == 0, "R2", enc_valid_o, 1);
      if (a < 2 && b < 2 && c < 2 && d < 2)
        check(code == {2'b00, a[0], b[0], 1'b0, c[0], d[0]}, "R3", code,
              {2'b00, a[0], b[0], 1'b0, c[0], d[0]});
      check(!seen[code], "R6 distinct", code, 0);
      check(!(code[6:5] == 2'b10 && !code[2]), "R6 reserved", code, 0);
      seen[code] = 1'b1;
      dec(code);
      check(dec_valid_o && !dec_invalid_o && dec_trits_o == t, "R5", dec_trits_o, t);
    end

    // R9 hold
    held = dec_trits_o[6:0];
    dec_code_i = 7'b1111111;
    @(negedge clk_i);
    check(!dec_valid_o && dec_trits_o[6:0] == held, "R9", dec_trits_o, held);

    // R8 sweep of all words
    n_valid = 0;
    for (int w = 0; w < 128; w++) begin
      dec(w[6:0]);
      check(dec_valid_o, "R9", dec_valid_o, 1);
      if (seen[w]) begin
        n_valid++;
        check(!dec_invalid_o, "R8 accepted", dec_invalid_o, 0);
      end else begin
        check(dec_invalid_o && dec_trits_o == 0, "R8 rejected", {dec_invalid_o, dec_trits_o}, 9'h100);
      end
    end
    check(n_valid == 81, "R8 count", n_valid, 81);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule